// File: doc/BRIEF.md
# SDH Transport Overhead Byte Inserter

This block supplies the transport overhead byte for every overhead position of an STM-4 frame, or of four byte-interleaved STM-1 lines. A framer presents each position as a row, multicolumn and depth index, all counted from zero. One cycle later the block returns the byte to transmit. Most positions are looked up in a host-written table of 324 nine-bit entries. The top bit of an entry chooses between the stored byte and the byte arriving on an external overhead port.

Some positions bypass that choice. The fourth row belongs to the pointer bytes and always carries the port byte. K1 and K2 come from one 16-bit register per line. A register write is held in a pending copy and moves to the live copy only on a frame-start pulse, so each frame carries a consistent pair. At B1 and B2, the parity byte supplied at the input is XORed with the table byte, which turns the table into an error-injection mask. At J0, a 64-byte trace store (16 bytes per line) supplies the next message byte. A 4-bit pointer per line steps once per J0 emission.

Top module: `toh_inserter`

## Requirements
- R1: At an ordinary position, bit 8 of the table entry selects the output. 0 gives entry bits 7:0 and 1 gives `port_byte`.
- R2: The entry index is row*36 + mcol*4 + depth, with row 0..8, mcol 0..8 and depth 0..3. In STM-1 mode (`stm4_mode`=0) the depth is the line number. In STM-4 mode it is the interleave depth.
- R3: After reset, entries 0..11 read 0x0F6, entries 12..23 read 0x028 and all other entries read 0. Also after reset, `oh_valid` and `oh_byte` are 0.
- R4: At row 3 the output is `port_byte`, whatever the table entry holds.
- R5: K1 (row 4, mcol 3) and K2 (row 4, mcol 6) are never taken from the table.
  - K1 comes from bits 15:8 of the live register for the position's line.
  - K2 comes from bits 7:0 of the same register.
  - The register for line L is written at host address 768+L.
  - In STM-4 mode only depth 0 is a K1 or K2 position, and it uses line 0. At other depths the table is used.
- R6: A K register write has no effect on the output until the next `frame_start` pulse. After that pulse the new value is used.
- R7: At B1 (row 1, mcol 0) and B2 (row 4, mcol 0..2) the output is `bip_byte` XOR table bits 7:0. In STM-4 mode B1 exists only at depth 0.
- R8: At J0 (row 0, mcol 6) the output is trace byte line*16+pointer.
  - Each line has its own 4-bit pointer. It advances on every emission and wraps from 15 to 0.
  - In STM-4 mode only depth 0 is J0, and it uses line 0, so only bytes 0..15 are used.
- R9: The host port is mapped as follows.
  - Addresses 0..323 are the table. A write stores `host_wdata` bits 8:0, and a read returns the entry zero-extended to 16 bits.
  - Addresses 512..575 are the trace store. A write stores bits 7:0, and a read returns the byte zero-extended.
  - Addresses 768..771 return the pending K word.
- R10: `oh_valid` equals `pos_valid` delayed by one cycle, and `oh_byte` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stm4_mode | input | 1 | 1 = STM-4, 0 = four STM-1 lines |
| pos_valid | input | 1 | A position is presented this cycle |
| pos_row | input | 4 | Overhead row, 0..8 |
| pos_mcol | input | 4 | Multicolumn, 0..8 |
| pos_depth | input | 2 | Interleave depth or line, 0..3 |
| frame_start | input | 1 | Frame boundary pulse; loads K registers |
| port_byte | input | 8 | Byte from the external overhead port |
| bip_byte | input | 8 | Computed parity byte for B1/B2 |
| host_addr | input | 10 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_we | input | 1 | Host write enable |
| host_rdata | output | 16 | Host read data (combinational) |
| oh_valid | output | 1 | Output byte valid |
| oh_byte | output | 8 | Overhead byte to transmit |

## Verification
The bench targets positions that look ordinary in one mode but are special in the other.
- A K1 slot at depth 1 in STM-4 mode must read the table. A design that ignored the mode would return a K byte there.
- A K write presented before the frame pulse must still give the old byte. A design without the pending copy would leak a half-updated pair.
- The J0 pointer is driven past 16 emissions and must wrap, and the lines are checked for independence. A design that shared one pointer, or failed to wrap, would emit the wrong message byte.
- Row 3 positions whose table entries were written must still return the port byte.
- Nonzero B masks must show up as flipped parity bits.

// File: rtl/toh_pkg.sv
package toh_pkg;
  localparam int TOH_ROWS   = 9;
  localparam int TOH_MCOLS  = 9;
  localparam int TOH_DEPTH  = 4;
  localparam int TOH_ENTRIES = TOH_ROWS * TOH_MCOLS * TOH_DEPTH;
  localparam int TOH_IW     = $clog2(TOH_ENTRIES);
  localparam int TRC_PER_LINE = 16;
  localparam int TRC_BYTES  = TRC_PER_LINE * TOH_DEPTH;

  typedef enum logic [2:0] {
    PK_TABLE, PK_PTR, PK_K1, PK_K2, PK_J0, PK_BIP
  } pos_kind_e;

  function automatic logic [TOH_IW-1:0] toh_index(input logic [3:0] r,
                                                  input logic [3:0] m,
                                                  input logic [1:0] d);
    return TOH_IW'(r) * TOH_IW'(TOH_MCOLS * TOH_DEPTH)
         + TOH_IW'(m) * TOH_IW'(TOH_DEPTH) + TOH_IW'(d);
  endfunction

  function automatic logic [8:0] toh_init(input int i);
    if (i < 12)      return 9'h0F6;
    else if (i < 24) return 9'h028;
    else             return 9'h000;
  endfunction

  function automatic pos_kind_e toh_classify(input logic [3:0] r,
                                             input logic [3:0] m,
                                             input logic [1:0] d,
                                             input logic stm4);
    logic first;
    first = !stm4 || (d == 2'd0);
    if (r == 4'd3)                           return PK_PTR;
    if (r == 4'd0 && m == 4'd6 && first)     return PK_J0;
    if (r == 4'd1 && m == 4'd0 && first)     return PK_BIP;
    if (r == 4'd4 && m <= 4'd2)              return PK_BIP;
    if (r == 4'd4 && m == 4'd3 && first)     return PK_K1;
    if (r == 4'd4 && m == 4'd6 && first)     return PK_K2;
    return PK_TABLE;
  endfunction
endpackage

// File: rtl/toh_table.sv
module toh_table
  import toh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TOH_IW-1:0] wr_idx,
  input  logic [8:0]        wr_data,
  input  logic [TOH_IW-1:0] host_idx,
  output logic [8:0]        host_entry,
  input  logic [TOH_IW-1:0] pos_idx,
  output logic [8:0]        pos_entry
);
  logic [8:0] mem [TOH_ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOH_ENTRIES; i++) mem[i] <= toh_init(i);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign host_entry = (int'(host_idx) < TOH_ENTRIES) ? mem[host_idx] : '0;
  assign pos_entry  = (int'(pos_idx)  < TOH_ENTRIES) ? mem[pos_idx]  : '0;
endmodule

// File: rtl/toh_trace.sv
module toh_trace
  import toh_pkg::*;
#(
  parameter int LINES = TOH_DEPTH,
  parameter int PER_LINE = TRC_PER_LINE,
  localparam int PW = $clog2(PER_LINE),
  localparam int LW = $clog2(LINES),
  localparam int BYTES = LINES * PER_LINE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW+PW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [LW+PW-1:0] host_idx,
  output logic [7:0]    host_byte,
  input  logic [LW-1:0] line,
  input  logic          advance,
  output logic [7:0]    j0_byte
);
  logic [7:0]    mem [BYTES];
  logic [PW-1:0] ptr [LINES];
  logic [LINES-1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_ptr
    assign step[g] = advance && (line == LW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       ptr[g] <= '0;
      else if (step[g]) ptr[g] <= ptr[g] + 1'b1;
    end
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !step[g] |=> $stable(ptr[g]));
  end

  assign host_byte = mem[host_idx];
  assign j0_byte   = mem[{line, ptr[line]}];

  assert_one_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step));
endmodule

// File: rtl/toh_kreg.sv
module toh_kreg #(
  parameter int LINES = 4,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic [15:0]   wr_data,
  input  logic          frame_start,
  input  logic [LW-1:0] host_line,
  output logic [15:0]   host_word,
  input  logic [LW-1:0] sel_line,
  output logic [15:0]   live_word
);
  logic [15:0] pend [LINES];
  logic [15:0] live [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_k
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= '0;
        live[g] <= '0;
      end else begin
        if (wr_en && wr_line == LW'(g)) pend[g] <= wr_data;
        if (frame_start)                live[g] <= pend[g];
      end
    end
    assert_k_frame_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(live[g]));
  end

  assign host_word = pend[host_line];
  assign live_word = live[sel_line];
endmodule

// File: rtl/toh_inserter.sv
module toh_inserter
  import toh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stm4_mode,
  input  logic        pos_valid,
  input  logic [3:0]  pos_row,
  input  logic [3:0]  pos_mcol,
  input  logic [1:0]  pos_depth,
  input  logic        frame_start,
  input  logic [7:0]  port_byte,
  input  logic [7:0]  bip_byte,
  input  logic [9:0]  host_addr,
  input  logic [15:0] host_wdata,
  input  logic        host_we,
  output logic [15:0] host_rdata,
  output logic        oh_valid,
  output logic [7:0]  oh_byte
);
  logic sel_tbl, sel_trc, sel_k;
  assign sel_tbl = int'(host_addr) < TOH_ENTRIES;
  assign sel_trc = host_addr[9:6] == 4'b1000;
  assign sel_k   = host_addr[9:2] == 8'hC0;

  pos_kind_e         kind;
  logic [TOH_IW-1:0] pos_idx;
  logic [1:0]        line;
  logic [8:0]        pos_entry, host_entry;
  logic [7:0]        trc_host, j0_byte;
  logic [15:0]       k_host, k_live;
  logic              j0_fire;
  logic [7:0]        next_byte;

  assign kind    = toh_classify(pos_row, pos_mcol, pos_depth, stm4_mode);
  assign pos_idx = toh_index(pos_row, pos_mcol, pos_depth);
  assign line    = stm4_mode ? 2'd0 : pos_depth;
  assign j0_fire = pos_valid && (kind == PK_J0);

  toh_table u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_we && sel_tbl), .wr_idx(host_addr[TOH_IW-1:0]),
    .wr_data(host_wdata[8:0]),
    .host_idx(host_addr[TOH_IW-1:0]), .host_entry(host_entry),
    .pos_idx(pos_idx), .pos_entry(pos_entry)
  );

  toh_trace u_trace (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_we && sel_trc), .wr_idx(host_addr[5:0]),
    .wr_data(host_wdata[7:0]),
    .host_idx(host_addr[5:0]), .host_byte(trc_host),
    .line(line), .advance(j0_fire), .j0_byte(j0_byte)
  );

  toh_kreg #(.LINES(TOH_DEPTH)) u_kreg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_we && sel_k), .wr_line(host_addr[1:0]),
    .wr_data(host_wdata), .frame_start(frame_start),
    .host_line(host_addr[1:0]), .host_word(k_host),
    .sel_line(line), .live_word(k_live)
  );

  always_comb begin
    if (sel_tbl)      host_rdata = {7'd0, host_entry};
    else if (sel_trc) host_rdata = {8'd0, trc_host};
    else if (sel_k)   host_rdata = k_host;
    else              host_rdata = '0;
  end

  always_comb begin
    unique case (kind)
      PK_PTR:  next_byte = port_byte;
      PK_K1:   next_byte = k_live[15:8];
      PK_K2:   next_byte = k_live[7:0];
      PK_J0:   next_byte = j0_byte;
      PK_BIP:  next_byte = bip_byte ^ pos_entry[7:0];
      default: next_byte = pos_entry[8] ? port_byte : pos_entry[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oh_valid <= 1'b0;
      oh_byte  <= '0;
    end else begin
      oh_valid <= pos_valid;
      if (pos_valid) oh_byte <= next_byte;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid |=> oh_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_valid |=> !oh_valid);
  assert_ptr_row_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && pos_row == 4'd3) |=> (oh_byte == $past(port_byte)));
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_valid |=> $stable(oh_byte));
  always_comb begin
    if (rst_n && pos_valid)
      assert_index_range_R2: assert (int'(pos_idx) < TOH_ENTRIES);
  end
endmodule

// File: tb/sim_toh_inserter.sv
module sim_toh_inserter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stm4_mode = 1'b0, pos_valid = 1'b0, frame_start = 1'b0, host_we = 1'b0;
  logic [3:0] pos_row = '0, pos_mcol = '0;
  logic [1:0] pos_depth = '0;
  logic [7:0] port_byte = '0, bip_byte = '0;
  logic [9:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic oh_valid;
  logic [7:0] oh_byte;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  toh_inserter u0 (.*);

  // {mode, row, mcol, depth, port, bip, expected}
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 4'd0, 4'd0, 2'd0, 8'h11, 8'h00, 8'hF6},  // R3 A1 reset value
    {1'b0, 4'd0, 4'd3, 2'd2, 8'h11, 8'h00, 8'h28},  // R3 A2 reset value
    {1'b0, 4'd0, 4'd7, 2'd1, 8'h11, 8'h00, 8'h00},  // R3 other zero
    {1'b0, 4'd2, 4'd1, 2'd2, 8'h33, 8'h00, 8'h5A},  // R1 table source
    {1'b0, 4'd2, 4'd1, 2'd3, 8'h33, 8'h00, 8'h33},  // R1 port source
    {1'b0, 4'd6, 4'd8, 2'd1, 8'h33, 8'h00, 8'hC3},  // R2 index 249
    {1'b0, 4'd1, 4'd0, 2'd0, 8'h00, 8'h3C, 8'h3D},  // R7 B1 mask
    {1'b0, 4'd4, 4'd2, 2'd3, 8'h00, 8'h0F, 8'h8F},  // R7 B2 mask
    {1'b0, 4'd4, 4'd0, 2'd1, 8'h00, 8'h55, 8'h55},  // R7 B2 clean
    {1'b0, 4'd3, 4'd0, 2'd0, 8'h99, 8'h00, 8'h99},  // R4 pointer row
    {1'b0, 4'd4, 4'd3, 2'd1, 8'h00, 8'h00, 8'hAB},  // R5 K1 line 1
    {1'b0, 4'd4, 4'd6, 2'd1, 8'h00, 8'h00, 8'hCD},  // R5 K2 line 1
    {1'b0, 4'd4, 4'd3, 2'd0, 8'h00, 8'h00, 8'h00},  // R5 K1 line 0
    {1'b1, 4'd1, 4'd0, 2'd1, 8'h22, 8'h3C, 8'h00},  // R7 STM-4 no B1 at depth 1
    {1'b1, 4'd4, 4'd3, 2'd1, 8'h00, 8'h00, 8'hFF},  // R5 STM-4 table at depth 1
    {1'b1, 4'd1, 4'd0, 2'd0, 8'h00, 8'h3C, 8'h3D}   // R7 STM-4 B1 depth 0
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic present(input logic m, input logic [3:0] r, input logic [3:0] c,
                         input logic [1:0] d, input logic [7:0] p, input logic [7:0] b,
                         output logic [7:0] got);
    @(negedge clk);
    stm4_mode = m; pos_row = r; pos_mcol = c; pos_depth = d;
    port_byte = p; bip_byte = b; pos_valid = 1'b1;
    @(negedge clk);
    pos_valid = 1'b0;
    got = oh_byte;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    check("R3 oh_valid", {15'd0, oh_valid}, 16'd0);
    check("R3 oh_byte", {8'd0, oh_byte}, 16'd0);
    hread(10'd0, rd);   check("R3 entry 0", rd, 16'h00F6);
    hread(10'd23, rd);  check("R3 entry 23", rd, 16'h0028);
    hread(10'd24, rd);  check("R3 entry 24", rd, 16'h0000);
    // setup
    hwrite(10'd78, 16'hFE5A);
    hwrite(10'd79, 16'h0100);
    hwrite(10'd249, 16'h00C3);
    hwrite(10'd36, 16'h0001);
    hwrite(10'd155, 16'h0080);
    hwrite(10'd157, 16'h00FF);
    hwrite(10'd108, 16'h0077);
    hwrite(10'd769, 16'hABCD);
    pulse_frame();
    // R9 host readback
    hread(10'd78, rd);  check("R9 table zero-extend", rd, 16'h005A);
    hread(10'd79, rd);  check("R9 table bit 8", rd, 16'h0100);
    hwrite(10'd517, 16'h1234);
    hread(10'd517, rd); check("R9 trace byte", rd, 16'h0034);
    hread(10'd769, rd); check("R9 K word", rd, 16'hABCD);
    // vector table
    for (int i = 0; i < NV; i++) begin
      present(VEC[i][34], VEC[i][33:30], VEC[i][29:26], VEC[i][25:24],
              VEC[i][23:16], VEC[i][15:8], got);
      check($sformatf("vector %0d R1/R2/R3/R4/R5/R7", i), {8'd0, got}, {8'd0, VEC[i][7:0]});
    end
    // R10 valid timing
    @(negedge clk);
    check("R10 idle oh_valid", {15'd0, oh_valid}, 16'd0);
    @(negedge clk);
    stm4_mode = 1'b0; pos_row = 4'd2; pos_mcol = 4'd1; pos_depth = 2'd2; pos_valid = 1'b1;
    #1 check("R10 not yet valid", {15'd0, oh_valid}, 16'd0);
    @(negedge clk);
    pos_valid = 1'b0;
    check("R10 valid after one cycle", {15'd0, oh_valid}, 16'd1);
    // R6 K shadow
    hwrite(10'd770, 16'h1122);
    present(1'b0, 4'd4, 4'd3, 2'd2, 8'h00, 8'h00, got);
    check("R6 K1 before frame", {8'd0, got}, 16'h0000);
    pulse_frame();
    present(1'b0, 4'd4, 4'd3, 2'd2, 8'h00, 8'h00, got);
    check("R6 K1 after frame", {8'd0, got}, 16'h0011);
    present(1'b0, 4'd4, 4'd6, 2'd2, 8'h00, 8'h00, got);
    check("R6 K2 after frame", {8'd0, got}, 16'h0022);
    // R8 trace
    for (int i = 0; i < 16; i++) hwrite(10'(512 + i), 16'(8'h40 + i));
    for (int i = 0; i < 16; i++) hwrite(10'(528 + i), 16'(8'h60 + i));
    for (int i = 0; i < 17; i++) begin
      present(1'b0, 4'd0, 4'd6, 2'd0, 8'h00, 8'h00, got);
      check($sformatf("R8 line0 J0 step %0d", i), {8'd0, got}, 16'(8'h40 + (i % 16)));
    end
    present(1'b0, 4'd0, 4'd6, 2'd1, 8'h00, 8'h00, got);
    check("R8 line1 own pointer", {8'd0, got}, 16'h0060);
    present(1'b1, 4'd0, 4'd6, 2'd0, 8'h00, 8'h00, got);
    check("R8 STM-4 uses line0", {8'd0, got}, 16'h0041);
    present(1'b1, 4'd0, 4'd6, 2'd1, 8'h00, 8'h00, got);
    check("R8 STM-4 depth1 not J0", {8'd0, got}, 16'h0000);
    present(1'b0, 4'd0, 4'd6, 2'd1, 8'h00, 8'h00, got);
    check("R8 line1 advanced once", {8'd0, got}, 16'h0061);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule